// File: doc/BRIEF.md
# NAND Ready/Busy and Event Status Register

This block is the status and interrupt-flag word of a NAND flash controller that drives four chip selects. It brings the four ready/busy lines from the flash devices into the clock domain through a two-stage synchronizer. It detects a chosen transition on each line and latches the result in sticky per-chip flags. A further sticky flag records transitions on line 0 only.

The same word holds three event flags. Each is set by a one-cycle pulse from a neighbouring unit: ECC encode complete, ECC decode complete, and a program or erase aimed at a locked region. The word also shows the live level of the four active-low chip-enable outputs.

Software reads the word as a 32-bit value. It clears any flag by writing a 1 to that flag's bit. Every sticky flag has its own interrupt enable. A single level-sensitive interrupt line is high while any enabled flag is set.

Top module: `nand_status_reg`

## Requirements
- R1: After reset, with all ready/busy pins high and all chip-enable inputs high, `rd_data` reads 0xF0000F0D.
- R2: Bits [31:28] show ready/busy pins 3..0, where 1 means ready and 0 means busy. Bit 0 repeats pin 0. Both follow a pin change after the second rising clock edge.
- R3: Bits [27:24] are sticky flags for chips 3..0. A flag is set at the third rising edge after its pin makes the selected transition. The opposite transition does not set it.
- R4: `edge_mode` selects the transition for all transition flags: 0 selects low-to-high and 1 selects high-to-low. Changing `edge_mode` while the pins are steady sets no flag.
- R5: Bit 4 is a sticky flag that only transitions on ready/busy pin 0 set. Transitions on pins 1..3 leave it clear.
- R6: A pulse on `enc_done` sets bit 7, a pulse on `dec_done` sets bit 6, and a pulse on `lock_violation` sets bit 5. Each bit is visible in the cycle after the pulse.
- R7: A write with bit n of `wr_data` at 1 clears sticky flag n (bits 27:24, 7, 6, 5, 4). A write with that bit at 0 leaves the flag unchanged.
- R8: When a set event and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R9: `irq` is high while any sticky flag is set together with its enable. The enables are `trans_irq_en[3:0]` for bits 27:24, `trans0_irq_en` for bit 4, `enc_irq_en` for bit 7, `dec_irq_en` for bit 6 and `lock_irq_en` for bit 5. `irq` stays high until every enabled set flag is cleared. A set flag whose enable is off does not raise it.
- R10: Bits [11:8] show `ce_n[3:0]`, bit 3 shows `ce_n[1]` and bit 2 shows `ce_n[0]`. Bits [23:12] and bit 1 read 0. Writes do not change the read-only or reserved bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rb_pin | input | 4 | Ready/busy lines from the flash devices (1 = ready) |
| ce_n | input | 4 | Active-low chip-enable outputs of the controller, mirrored |
| edge_mode | input | 1 | Transition select: 0 low-to-high, 1 high-to-low |
| enc_done | input | 1 | One-cycle pulse: ECC encode complete |
| dec_done | input | 1 | One-cycle pulse: ECC decode complete |
| lock_violation | input | 1 | One-cycle pulse: program/erase to a locked region |
| trans_irq_en | input | 4 | Interrupt enables for per-chip transition flags |
| trans0_irq_en | input | 1 | Interrupt enable for the chip-0 transition flag |
| enc_irq_en | input | 1 | Interrupt enable for the encode flag |
| dec_irq_en | input | 1 | Interrupt enable for the decode flag |
| lock_irq_en | input | 1 | Interrupt enable for the illegal-access flag |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; 1 bits clear the matching flags |
| rd_data | output | 32 | Register read value |
| irq | output | 1 | Level interrupt |

## Verification
The bench times each ready/busy change against the synchronizer. If the pipeline were one stage short or one stage long, the level bits or the flag would show up a cycle early or late. It drives falling edges in rising mode and the other way round, and changes the mode while the pins are steady. A detector with the wrong polarity, or one that compares against the mode rather than the previous level, would set flags it should not set. It fires an event pulse and a write-1 clear at the same flag in the same cycle, where a clear-priority flag would lose the event. It also writes zeros and all-ones over read-only fields, where a mask error would clear flags or corrupt the mirrored bits. Its interrupt cases enable flags one at a time and clear them in turn, which exposes a missing mask or an interrupt that drops while another enabled flag is still set.

// File: rtl/nand_stat_pkg.sv
package nand_stat_pkg;
  localparam int NUM_CE   = 4;
  localparam int REG_W    = 32;
  localparam int LVL_LSB  = 28;
  localparam int HIT_LSB  = 24;
  localparam int CE_LSB   = 8;
  localparam int B_ENC    = 7;
  localparam int B_DEC    = 6;
  localparam int B_LOCK   = 5;
  localparam int B_HIT0   = 4;
  localparam int B_CE1    = 3;
  localparam int B_CE0    = 2;
  localparam int B_RB0    = 0;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_mode_e;

  typedef struct packed {
    logic enc;
    logic dec;
    logic lock;
    logic hit0;
  } evt_flags_t;
endpackage

// File: rtl/rb_sync.sv
module rb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rb_edge_det.sv
module rb_edge_det
  import nand_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  edge_mode_e mode,
  output logic       hit
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = lvl;
    unique case (mode)
      EDGE_RISE: hit = lvl & ~prev_q;
      EDGE_FALL: hit = ~lvl & prev_q;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  // R4: with the mode held, one transition yields one single-cycle hit
  a_r4_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (!hit || (mode != $past(mode))));
endmodule

// File: rtl/w1c_flag.sv
module w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic upd_en;
  logic q_d;

  always_comb begin
    upd_en = set | clr;
    q_d    = set ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (upd_en) q <= q_d;
  end

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set) |=> $stable(q));
endmodule

// File: rtl/nand_status_reg.sv
module nand_status_reg
  import nand_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CE-1:0] rb_pin,
  input  logic [NUM_CE-1:0] ce_n,
  input  logic              edge_mode,
  input  logic              enc_done,
  input  logic              dec_done,
  input  logic              lock_violation,
  input  logic [NUM_CE-1:0] trans_irq_en,
  input  logic              trans0_irq_en,
  input  logic              enc_irq_en,
  input  logic              dec_irq_en,
  input  logic              lock_irq_en,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq
);
  localparam int EN_W = NUM_CE + 4;

  edge_mode_e        mode;
  logic [NUM_CE-1:0] rb_lvl;
  logic [NUM_CE-1:0] rb_hit;
  logic [NUM_CE-1:0] hit_flag;
  evt_flags_t        evt_set;
  evt_flags_t        evt_clr;
  evt_flags_t        evt_q;
  logic [EN_W-1:0]   en_vec;
  logic [EN_W-1:0]   flag_vec;

  assign mode = edge_mode_e'(edge_mode);

  for (genvar c = 0; c < NUM_CE; c++) begin : g_chip
    rb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d   (rb_pin[c]),
      .q   (rb_lvl[c])
    );

    rb_edge_det u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (rb_lvl[c]),
      .mode  (mode),
      .hit   (rb_hit[c])
    );

    w1c_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (rb_hit[c]),
      .clr   (wr_en & wr_data[HIT_LSB + c]),
      .q     (hit_flag[c])
    );
  end

  always_comb begin
    evt_set.enc  = enc_done;
    evt_set.dec  = dec_done;
    evt_set.lock = lock_violation;
    evt_set.hit0 = rb_hit[0];
    evt_clr.enc  = wr_en & wr_data[B_ENC];
    evt_clr.dec  = wr_en & wr_data[B_DEC];
    evt_clr.lock = wr_en & wr_data[B_LOCK];
    evt_clr.hit0 = wr_en & wr_data[B_HIT0];
  end

  w1c_flag u_enc_flag (
    .clk (clk), .rst_n (rst_n), .set (evt_set.enc), .clr (evt_clr.enc), .q (evt_q.enc)
  );
  w1c_flag u_dec_flag (
    .clk (clk), .rst_n (rst_n), .set (evt_set.dec), .clr (evt_clr.dec), .q (evt_q.dec)
  );
  w1c_flag u_lock_flag (
    .clk (clk), .rst_n (rst_n), .set (evt_set.lock), .clr (evt_clr.lock), .q (evt_q.lock)
  );
  w1c_flag u_hit0_flag (
    .clk (clk), .rst_n (rst_n), .set (evt_set.hit0), .clr (evt_clr.hit0), .q (evt_q.hit0)
  );

  always_comb begin
    rd_data                          = '0;
    rd_data[LVL_LSB +: NUM_CE]       = rb_lvl;
    rd_data[HIT_LSB +: NUM_CE]       = hit_flag;
    rd_data[CE_LSB +: NUM_CE]        = ce_n;
    rd_data[B_ENC]                   = evt_q.enc;
    rd_data[B_DEC]                   = evt_q.dec;
    rd_data[B_LOCK]                  = evt_q.lock;
    rd_data[B_HIT0]                  = evt_q.hit0;
    rd_data[B_CE1]                   = ce_n[1];
    rd_data[B_CE0]                   = ce_n[0];
    rd_data[B_RB0]                   = rb_lvl[0];
  end

  always_comb begin
    en_vec   = {trans_irq_en, enc_irq_en, dec_irq_en, lock_irq_en, trans0_irq_en};
    flag_vec = {hit_flag, evt_q.enc, evt_q.dec, evt_q.lock, evt_q.hit0};
    irq      = |(en_vec & flag_vec);
  end

  // R9: flags only fall on a write, so irq cannot drop without one unless enables change
  a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_en) |=> (irq || (en_vec != $past(en_vec))));

  // R6: an encode pulse is visible in the next cycle
  a_r6_enc_seen: assert property (@(posedge clk) disable iff (!rst_n)
    enc_done |=> rd_data[B_ENC]);

  // R2: level bits follow the pins after the synchronizer (two-stage build)
  if (SYNC_STAGES == 2) begin : g_lvl_chk
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end
    a_r2_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (rd_data[LVL_LSB +: NUM_CE] == $past(rb_pin, 2)));
  end
endmodule

// File: tb/nand_status_reg_bench.sv
`timescale 1ns/1ps
module nand_status_reg_bench;
  logic        clk;
  logic        rst_n;
  logic [3:0]  rb_pin;
  logic [3:0]  ce_n;
  logic        edge_mode;
  logic        enc_done, dec_done, lock_violation;
  logic [3:0]  trans_irq_en;
  logic        trans0_irq_en, enc_irq_en, dec_irq_en, lock_irq_en;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  nand_status_reg u_nand_status_reg (
    .clk (clk), .rst_n (rst_n), .rb_pin (rb_pin), .ce_n (ce_n),
    .edge_mode (edge_mode), .enc_done (enc_done), .dec_done (dec_done),
    .lock_violation (lock_violation), .trans_irq_en (trans_irq_en),
    .trans0_irq_en (trans0_irq_en), .enc_irq_en (enc_irq_en),
    .dec_irq_en (dec_irq_en), .lock_irq_en (lock_irq_en),
    .wr_en (wr_en), .wr_data (wr_data), .rd_data (rd_data), .irq (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    check("R1 reset value", rd_data, 32'hF000_0F0D);
    check("R9 irq after reset", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_rise_chip(input int c);
    rb_pin[c] = 1'b0;
    step(4);
    check("R2 busy level", {28'd0, rd_data[31:28]}, {28'd0, 4'hF & ~(4'd1 << c)});
    check("R3 fall ignored in rise mode", {28'd0, rd_data[27:24]}, 32'd0);
    rb_pin[c] = 1'b1;
    step(2);
    check("R2 ready level after two edges", {28'd0, rd_data[31:28]}, 32'hF);
    check("R3 flag not yet at second edge", {28'd0, rd_data[27:24]}, 32'd0);
    step(1);
    check("R3 flag at third edge", {28'd0, rd_data[27:24]}, {28'd0, 4'd1 << c});
    check("R5 chip0 flag only for pin 0", {31'd0, rd_data[4]}, {31'd0, c == 0});
    write_reg(32'h0F00_0010);
    check("R7 clear transition flags", rd_data & 32'h0F00_0010, 32'd0);
  endtask

  task automatic t_fall_mode;
    edge_mode = 1'b1;
    step(3);
    check("R4 mode change sets nothing", rd_data & 32'h0F00_0010, 32'd0);
    rb_pin[2] = 1'b0;
    step(3);
    check("R4 fall sets chip2 flag", {28'd0, rd_data[27:24]}, 32'h4);
    check("R5 chip2 fall leaves bit4", {31'd0, rd_data[4]}, 32'd0);
    rb_pin[0] = 1'b0;
    step(3);
    check("R5 pin0 fall sets bit4", rd_data & 32'h0F00_0010, 32'h0500_0010);
    write_reg(32'h0F00_0010);
    rb_pin = 4'hF;
    step(4);
    check("R4 rise ignored in fall mode", rd_data & 32'h0F00_0010, 32'd0);
    edge_mode = 1'b0;
    step(2);
  endtask

  task automatic t_events;
    enc_done = 1'b1; step(1); enc_done = 1'b0;
    check("R6 encode flag", {31'd0, rd_data[7]}, 32'd1);
    dec_done = 1'b1; step(1); dec_done = 1'b0;
    check("R6 decode flag", {31'd0, rd_data[6]}, 32'd1);
    lock_violation = 1'b1; step(1); lock_violation = 1'b0;
    check("R6 lock flag", rd_data & 32'hE0, 32'hE0);
    write_reg(32'h0000_0000);
    check("R7 zero write keeps flags", rd_data & 32'hE0, 32'hE0);
    write_reg(32'h0000_0040);
    check("R7 clear only bit6", rd_data & 32'hE0, 32'hA0);
    write_reg(32'h0000_00A0);
    check("R7 clear bits 7 and 5", rd_data & 32'hE0, 32'h00);
  endtask

  task automatic t_set_wins;
    dec_done = 1'b1; wr_en = 1'b1; wr_data = 32'h40;
    step(1);
    dec_done = 1'b0; wr_en = 1'b0; wr_data = '0;
    check("R8 set beats clear", {31'd0, rd_data[6]}, 32'd1);
    write_reg(32'h40);
    check("R8 later clear works", {31'd0, rd_data[6]}, 32'd0);
  endtask

  task automatic t_irq;
    enc_done = 1'b1; step(1); enc_done = 1'b0;
    check("R9 disabled flag no irq", {31'd0, irq}, 32'd0);
    enc_irq_en = 1'b1; #1;
    check("R9 enabled flag irq", {31'd0, irq}, 32'd1);
    dec_done = 1'b1; step(1); dec_done = 1'b0;
    dec_irq_en = 1'b1;
    write_reg(32'h80);
    check("R9 irq held by decode flag", {31'd0, irq}, 32'd1);
    write_reg(32'h40);
    check("R9 irq low after all cleared", {31'd0, irq}, 32'd0);
    enc_irq_en = 1'b0; dec_irq_en = 1'b0;
    trans_irq_en = 4'b1000;
    rb_pin[3] = 1'b0; step(4);
    rb_pin[3] = 1'b1; step(3);
    check("R9 transition irq", {31'd0, irq}, 32'd1);
    write_reg(32'h0800_0000);
    check("R9 transition irq cleared", {31'd0, irq}, 32'd0);
    trans_irq_en = 4'd0;
  endtask

  task automatic t_ce_reserved;
    ce_n = 4'b1010; #1;
    check("R10 ce mirror", rd_data & 32'h0000_0F0C, 32'h0000_0A08);
    write_reg(32'hFFFF_FFFF);
    check("R10 writes leave RO/reserved", rd_data, 32'hF000_0A09);
    ce_n = 4'hF; #1;
    check("R10 ce back to idle", rd_data, 32'hF000_0F0D);
  endtask

  initial begin
    rst_n = 1'b0; rb_pin = 4'hF; ce_n = 4'hF; edge_mode = 1'b0;
    enc_done = 0; dec_done = 0; lock_violation = 0;
    trans_irq_en = 4'd0; trans0_irq_en = 0; enc_irq_en = 0; dec_irq_en = 0; lock_irq_en = 0;
    wr_en = 0; wr_data = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    for (int c = 0; c < 4; c++) t_rise_chip(c);
    t_fall_mode();
    t_events();
    t_set_wins();
    t_irq();
    t_ce_reserved();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule